// File: doc/BRIEF.md
# Segmented Active-Bit Bus Encoder

This block pairs a transmitter and a receiver around a wide unsigned instruction bus to cut switching on high-order lines that carry no information. The word is split into equal segments. The transmitter finds the highest segment that holds a set bit. It drives that segment and every segment below it with the new data. Every segment above it keeps whatever value the bus already carries. A narrow side-band code tells the receiver how many low segments are meaningful.

The receiver passes the meaningful segments through and forces the rest to zero. This rebuilds the original word exactly. To save a side-band line, a count of "all but the top segment" shares its code with "all segments", and in that case the whole bus is driven. Setting the segment count equal to the word width gives per-bit granularity. The default configuration treats a 40-bit word as eight 5-bit segments.

Top module: `seg_bus_link`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `line_data` is all zeros, `line_code` is zero and `line_strobe` and `rx_valid` are low.
- R2: One clock after a transfer (`tx_valid` high), `rx_word` equals the word sent and `rx_valid` is high.
- R3: Let k be the index of the highest segment of `tx_word` holding a set bit (segment 0 at the LSB). Segments with an index above k keep the `line_data` value from before the transfer, unless R6 applies.
- R4: Segments 0 through k of `line_data` carry the corresponding bits of `tx_word` after the transfer.
- R5: `line_code` (binary, `$clog2(SEG_COUNT)` bits) carries the number of active segments, k+1. The count SEG_COUNT is sent as SEG_COUNT-1.
- R6: When `line_code` is SEG_COUNT-1, every segment of `line_data` carries the new word, including a top segment that is zero.
- R7: A zero word gives code 0 and leaves every `line_data` bit unchanged.
- R8: Without `tx_valid`, `line_data` and `line_code` hold, and `line_strobe` and `rx_valid` are low on the next cycle.
- R9: The receiver forces to zero every segment whose index is at or above `line_code`, except when the code is SEG_COUNT-1.
- R10: With SEG_COUNT equal to DATA_W (one bit per segment), the rules above hold per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transfer request this cycle |
| tx_word | input | DATA_W | Unsigned word to send |
| line_data | output | DATA_W | Registered bus lines |
| line_code | output | $clog2(SEG_COUNT) | Registered side-band active-segment code |
| line_strobe | output | 1 | Registered marker of a new transfer on the lines |
| rx_word | output | DATA_W | Word rebuilt by the receiver |
| rx_valid | output | 1 | Rebuilt word is fresh |

## Verification
The assertions assume that `tx_valid` and `tx_word` are settled at each rising edge. They also assume that the lines reach the receiver unchanged, with no other driver between the two ends, so that the held upper segments are the transmitter's own previous values. The bench meets these assumptions by driving inputs only on falling edges. Its stimulus walks every 8-bit word in a scrambled order, so each transfer follows a different held value. Idle cycles and repeated zero words test the hold paths.

// File: rtl/seg_lead_find.sv
module seg_lead_find #(
  parameter int DATA_W    = 40,
  parameter int SEG_COUNT = 8,
  localparam int SEG_W    = DATA_W / SEG_COUNT,
  localparam int CODE_W   = $clog2(SEG_COUNT)
) (
  input  logic [DATA_W-1:0] word,
  output logic [CODE_W-1:0] code
);
  logic [SEG_COUNT-1:0] seg_nz;

  generate
    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_nz
      assign seg_nz[s] = |word[s*SEG_W +: SEG_W];
    end
  endgenerate

  // highest nonzero segment wins; counts N-1 and N share one code
  always_comb begin
    code = '0;
    for (int s = 0; s < SEG_COUNT; s++) begin
      if (seg_nz[s]) begin
        if (s >= SEG_COUNT - 2) code = CODE_W'(SEG_COUNT - 1);
        else                    code = CODE_W'(s + 1);
      end
    end
  end
endmodule

// File: rtl/seg_enable_map.sv
module seg_enable_map #(
  parameter int SEG_COUNT = 8,
  localparam int CODE_W   = $clog2(SEG_COUNT)
) (
  input  logic [CODE_W-1:0]    code,
  output logic [SEG_COUNT-1:0] seg_en
);
  logic full;
  assign full = (code == CODE_W'(SEG_COUNT - 1));

  generate
    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_en
      assign seg_en[s] = full || (CODE_W'(s) < code);
    end
  endgenerate
endmodule

// File: rtl/seg_bus_tx.sv
module seg_bus_tx #(
  parameter int DATA_W    = 40,
  parameter int SEG_COUNT = 8,
  localparam int SEG_W    = DATA_W / SEG_COUNT,
  localparam int CODE_W   = $clog2(SEG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_word,
  output logic [DATA_W-1:0] line_data,
  output logic [CODE_W-1:0] line_code,
  output logic              line_strobe
);
  logic [CODE_W-1:0]    code_nx;
  logic [SEG_COUNT-1:0] seg_en;
  logic [DATA_W-1:0]    data_nx;

  seg_lead_find #(.DATA_W(DATA_W), .SEG_COUNT(SEG_COUNT)) u_find (
    .word (tx_word),
    .code (code_nx)
  );

  seg_enable_map #(.SEG_COUNT(SEG_COUNT)) u_map (
    .code   (code_nx),
    .seg_en (seg_en)
  );

  generate
    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_mux
      assign data_nx[s*SEG_W +: SEG_W] =
        seg_en[s] ? tx_word[s*SEG_W +: SEG_W] : line_data[s*SEG_W +: SEG_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      line_data   <= '0;
      line_code   <= '0;
      line_strobe <= 1'b0;
    end else begin
      line_strobe <= tx_valid;
      if (tx_valid) begin
        line_data <= data_nx;
        line_code <= code_nx;
      end
    end
  end

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |=> ($stable(line_data) && $stable(line_code) && !line_strobe));

  a_r7_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_word == '0) |=> ($stable(line_data) && line_code == '0));

  a_r6_top_full: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_word[DATA_W-1 -: SEG_W] != '0)
      |=> (line_data == $past(tx_word) && line_code == CODE_W'(SEG_COUNT - 1)));
endmodule

// File: rtl/seg_bus_rx.sv
module seg_bus_rx #(
  parameter int DATA_W    = 40,
  parameter int SEG_COUNT = 8,
  localparam int SEG_W    = DATA_W / SEG_COUNT,
  localparam int CODE_W   = $clog2(SEG_COUNT)
) (
  input  logic [DATA_W-1:0] line_data,
  input  logic [CODE_W-1:0] line_code,
  input  logic              line_strobe,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid
);
  logic [SEG_COUNT-1:0] seg_en;

  seg_enable_map #(.SEG_COUNT(SEG_COUNT)) u_map (
    .code   (line_code),
    .seg_en (seg_en)
  );

  generate
    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_zero
      assign rx_word[s*SEG_W +: SEG_W] =
        seg_en[s] ? line_data[s*SEG_W +: SEG_W] : '0;
    end
  endgenerate

  assign rx_valid = line_strobe;
endmodule

// File: rtl/seg_bus_link.sv
module seg_bus_link #(
  parameter int DATA_W    = 40,
  parameter int SEG_COUNT = 8,
  localparam int CODE_W   = $clog2(SEG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_word,
  output logic [DATA_W-1:0] line_data,
  output logic [CODE_W-1:0] line_code,
  output logic              line_strobe,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid
);
  initial begin
    assert (SEG_COUNT >= 2 && (SEG_COUNT & (SEG_COUNT - 1)) == 0
            && DATA_W % SEG_COUNT == 0)
      else $error("segment count must be a power of two dividing the width");
  end

  seg_bus_tx #(.DATA_W(DATA_W), .SEG_COUNT(SEG_COUNT)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .tx_valid    (tx_valid),
    .tx_word     (tx_word),
    .line_data   (line_data),
    .line_code   (line_code),
    .line_strobe (line_strobe)
  );

  seg_bus_rx #(.DATA_W(DATA_W), .SEG_COUNT(SEG_COUNT)) u_rx (
    .line_data   (line_data),
    .line_code   (line_code),
    .line_strobe (line_strobe),
    .rx_word     (rx_word),
    .rx_valid    (rx_valid)
  );

  a_r2_round_trip: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> (rx_valid && rx_word == $past(tx_word)));
endmodule

// File: tb/seg_bus_link_bench.sv
module seg_bus_link_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int NA = 4;   // 2-bit segments
  localparam int NB = 8;   // per-bit granularity

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_valid = 1'b0;
  logic [W-1:0] tx_word = '0;

  logic [W-1:0] a_line, a_rx, b_line, b_rx;
  logic [1:0]   a_code;
  logic [2:0]   b_code;
  logic a_strb, a_rv, b_strb, b_rv;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_a = '0, exp_b = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_bus_link #(.DATA_W(W), .SEG_COUNT(NA)) u_seg_bus_link (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_word(tx_word),
    .line_data(a_line), .line_code(a_code), .line_strobe(a_strb),
    .rx_word(a_rx), .rx_valid(a_rv));

  seg_bus_link #(.DATA_W(W), .SEG_COUNT(NB)) u_seg_bus_link_bit (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_word(tx_word),
    .line_data(b_line), .line_code(b_code), .line_strobe(b_strb),
    .rx_word(b_rx), .rx_valid(b_rv));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int code_of(input int w, input int nseg);
    int segw = W / nseg;
    int hi = -1;
    int cnt;
    for (int b = 0; b < W; b++) if (w[b]) hi = b;
    cnt = (hi < 0) ? 0 : hi / segw + 1;
    return (cnt == nseg) ? nseg - 1 : cnt;
  endfunction

  function automatic int line_of(input int w, input int prev, input int nseg);
    int segw = W / nseg;
    int c = code_of(w, nseg);
    int nd = (c == nseg - 1) ? nseg : c;
    int r = 0;
    for (int b = 0; b < W; b++)
      r[b] = (b / segw < nd) ? w[b] : prev[b];
    return r;
  endfunction

  task automatic send(input int w);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_word  = W'(w);
    @(posedge clk);
    #1;
    exp_a = W'(line_of(w, int'(exp_a), NA));
    exp_b = W'(line_of(w, int'(exp_b), NB));
    check("R3/R4/R6 line A", int'(a_line), int'(exp_a));
    check("R5 code A", int'(a_code), code_of(w, NA));
    check("R2/R9 rx A", int'(a_rx), w);
    check("R2 rx_valid A", int'(a_rv), 1);
    check("R10 line B", int'(b_line), int'(exp_b));
    check("R10 code B", int'(b_code), code_of(w, NB));
    check("R10 rx B", int'(b_rx), w);
  endtask

  task automatic idle();
    @(negedge clk);
    tx_valid = 1'b0;
    tx_word  = 8'hA5;
    @(posedge clk);
    #1;
    check("R8 hold A", int'(a_line), int'(exp_a));
    check("R8 hold B", int'(b_line), int'(exp_b));
    check("R8 strobe", int'(a_strb) + int'(b_rv), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset line", int'(a_line) + int'(b_line), 0);
    check("R1 reset code", int'(a_code) + int'(b_code), 0);
    check("R1 reset strobe", int'(a_strb) + int'(a_rv), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 after reset", int'(a_line) + int'(b_code) + int'(b_strb), 0);

    // R7: zero word leaves lines untouched
    send(8'hFF);
    send(0);
    check("R7 zero keeps A", int'(a_line), 8'hFF);
    check("R7 zero code", int'(a_code), 0);
    // R6: count N-1 drives the zero top segment
    send(8'h3F);
    check("R6 top driven A", int'(a_line), 8'h3F);
    // R3: high segments hold
    send(8'hC0);
    send(8'h01);
    check("R3 hold upper A", int'(a_line), 8'hC1);

    for (int i = 0; i < 256; i++) begin
      send((i * 37 + 11) & 255);
      if (i % 16 == 5) idle();
      if (i % 32 == 9) send(0);
    end
    for (int i = 0; i < 256; i++) send(i ^ 8'h55);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule